// File: doc/BRIEF.md
# Host-Coprocessor Mailbox and Shared-RAM Bridge

This block connects a 16-bit host bus to the work RAM of an attached coprocessor and gives the two sides a small mailbox for passing commands. The bus decoder above the bridge raises one select per host region. The first region is a direct RAM window that can be read and written. Two more regions are read-only views of the same RAM in which the word address bits are permuted, so that a linear host scan walks the RAM in tile order. The last region is a register area. Within it, a 16-byte mailbox block is handled locally, and every other address is forwarded to a generic I/O port.

The mailbox holds a 16-bit transfer word and a 16-bit status word, and the coprocessor sees both at all times. A host write of the transfer word sets a "host has posted" status flag and pulses a release strobe towards the coprocessor. A host read of the status word clears status bit 0 as a side effect, which gives the two sides a read-to-clear handshake. The coprocessor can also poll two words in RAM. A nonzero host write to either of them pulses a matching wake strobe.

Every host read returns its data, with a valid flag, one clock after the request. A byte read selects one lane of the 16-bit word it reads.

Top module: `cop_mailbox_bridge`

## Requirements
- R1: A host word read at mailbox byte offset 0 or 2 returns the transfer word.
- R2: A host read at mailbox offset 4 or 5 returns the status word as it was before the read. In the next cycle, status bit 0 reads as 0 on `cop_status`, unless the coprocessor sets that bit in the same cycle.
- R3: A host word write at mailbox offset 0 or 2 loads `cop_xfer` and sets status bit 1. It also pulses `rel_mbox` high for exactly one cycle, in the cycle after the request.
- R4: A read in tile window A at host word index w (bits 15:1 of `host_off`) reads RAM word ((w & 0x7001) | ((w & 0x3e) << 6) | ((w & 0xfc0) >> 5)).
- R5: A read in tile window B at host word index w reads RAM word ((w & 0x7801) | ((w & 0x1e) << 6) | ((w & 0x7e0) >> 4)).
- R6: A host word write in the direct window always stores its data. It pulses `rel_wake_a` (byte offset 0x0fe06) or `rel_wake_b` (byte offset 0x0fe08) for one cycle after the request, but only if the data is nonzero and the offset lies in the lower half of the window. Offset 0x1fe06 gives no pulse.
- R7: A host byte read (`host_byte` = 1) in the mailbox or RAM regions has the same side effects as the word read. It returns the high byte for an even offset and the low byte for an odd offset, in bits 7:0 with bits 15:8 zero.
- R8: In the register region, an access outside the mailbox block at byte offset 0x05000 to 0x0500f raises `io_req` in the same cycle and forwards the write enable, byte flag, offset and data to the I/O port. A read returns `io_rdata` unchanged one cycle later.
- R9: Host writes into either tile window never assert `ram_we`.
- R10: Every host read request produces `host_rvalid` = 1 in the next cycle only.
- R11: `cop_set` and `cop_clr` set and clear status bits in the cycle after they are applied, and a set wins over any clear of the same bit. `cop_xfer_we` loads the transfer word. A host transfer write in the same cycle takes precedence over it.
- R12: Host writes at mailbox offsets 4 to 15 change neither register. Host reads at offsets 6 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_byte | input | 1 | Byte access; host byte writes are dropped except on the I/O port |
| host_sel_ram | input | 1 | Direct RAM window select |
| host_sel_tile_a | input | 1 | Tile window A select |
| host_sel_tile_b | input | 1 | Tile window B select |
| host_sel_regs | input | 1 | Register region select |
| host_off | input | 17 | Byte offset inside the selected region |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rvalid | output | 1 | Read data valid, one cycle after the request |
| ram_addr | output | 16 | Shared RAM word address |
| ram_re | output | 1 | RAM read enable (data expected next cycle) |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data |
| io_req | output | 1 | Forwarded register-region access |
| io_we | output | 1 | Forwarded write enable |
| io_byte | output | 1 | Forwarded byte flag |
| io_addr | output | 17 | Forwarded byte offset |
| io_wdata | output | 16 | Forwarded write data |
| io_rdata | input | 16 | I/O read data, one cycle after `io_req` |
| cop_set | input | 16 | Coprocessor status set mask |
| cop_clr | input | 16 | Coprocessor status clear mask |
| cop_xfer_we | input | 1 | Coprocessor transfer word load |
| cop_xfer_wdata | input | 16 | Coprocessor transfer word data |
| cop_xfer | output | 16 | Current transfer word |
| cop_status | output | 16 | Current status word |
| rel_mbox | output | 1 | Release pulse after a host transfer write |
| rel_wake_a | output | 1 | Wake pulse for RAM word A |
| rel_wake_b | output | 1 | Wake pulse for RAM word B |

## Verification
The status word has two writers, and both can act in the same cycle. A host read of offset 4 clears bit 0 while `cop_set` sets it again. A host transfer write sets bit 1 while `cop_xfer_we` tries to load the transfer word. The bench drives each pair in one request cycle. It checks that the read still returns the pre-read status, and that the next cycle shows the coprocessor's set bit held and the host's transfer data kept.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
   localparam int TILE_IW = 15;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_RAM,
      RG_TILE_A,
      RG_TILE_B,
      RG_MBOX,
      RG_IO
   } region_e;
endpackage

// File: rtl/cmb_tile_perm.sv
module cmb_tile_perm
   import cmb_pkg::*;
#(
   parameter int VARIANT = 0
) (
   input  logic [TILE_IW-1:0] word_idx,
   output logic [TILE_IW-1:0] ram_idx
);
   generate
      if (VARIANT == 0) begin : g_perm_a
         // 6-bit column field moves down, 5-bit row field moves up
         assign ram_idx = {word_idx[14:12], word_idx[5:1], word_idx[11:6], word_idx[0]};
      end else if (VARIANT == 1) begin : g_perm_b
         // 6-bit column field moves down, 4-bit row field moves up
         assign ram_idx = {word_idx[14:11], word_idx[4:1], word_idx[10:5], word_idx[0]};
      end else begin : g_bad
         $error("cmb_tile_perm: VARIANT must be 0 or 1");
         assign ram_idx = word_idx;
      end
   endgenerate
endmodule

// File: rtl/cmb_mbox_regs.sv
module cmb_mbox_regs #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          h_rd,
   input  logic          h_wr,
   input  logic [2:0]    h_woff,
   input  logic [DW-1:0] h_wdata,
   input  logic [DW-1:0] cop_set,
   input  logic [DW-1:0] cop_clr,
   input  logic          cop_xfer_we,
   input  logic [DW-1:0] cop_xfer_wdata,
   output logic [DW-1:0] rd_data,
   output logic [DW-1:0] xfer,
   output logic [DW-1:0] status,
   output logic          rel_mbox
);
   localparam logic [DW-1:0] POSTED_BIT = DW'(2);
   localparam logic [DW-1:0] ACK_BIT    = DW'(1);

   logic xfer_hit, stat_hit, wr_x, rd_s;
   logic [DW-1:0] host_set, host_clr, status_n, xfer_n;

   assign xfer_hit = (h_woff[2:1] == 2'b00);
   assign stat_hit = (h_woff == 3'b010);
   assign wr_x     = h_wr && xfer_hit;
   assign rd_s     = h_rd && stat_hit;
   assign host_set = wr_x ? POSTED_BIT : '0;
   assign host_clr = rd_s ? ACK_BIT : '0;

   always_comb begin
      status_n = (status & ~host_clr & ~cop_clr) | host_set | cop_set;
      if (wr_x)             xfer_n = h_wdata;
      else if (cop_xfer_we) xfer_n = cop_xfer_wdata;
      else                  xfer_n = xfer;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer     <= '0;
         status   <= '0;
         rd_data  <= '0;
         rel_mbox <= 1'b0;
      end else begin
         xfer     <= xfer_n;
         status   <= status_n;
         rel_mbox <= wr_x;
         if (h_rd)
            rd_data <= xfer_hit ? xfer : (stat_hit ? status : '0);
      end
   end

   AST_POSTED_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      wr_x |=> status[1]); // R3
   AST_READ_CLEARS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_s && !cop_set[0]) |=> !status[0]); // R2
   AST_COP_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cop_set[0] |=> status[0]); // R11
   AST_RELEASE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_mbox && !$past(wr_x)) |-> 1'b0); // R3
endmodule

// File: rtl/cop_mailbox_bridge.sv
module cop_mailbox_bridge
   import cmb_pkg::*;
#(
   parameter int HOFF_W     = 17,
   parameter int DW         = 16,
   parameter int MBOX_BASE  = 'h05000,
   parameter int WAKE_A_OFF = 'h0fe06,
   parameter int WAKE_B_OFF = 'h0fe08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic              host_byte,
   input  logic              host_sel_ram,
   input  logic              host_sel_tile_a,
   input  logic              host_sel_tile_b,
   input  logic              host_sel_regs,
   input  logic [HOFF_W-1:0] host_off,
   input  logic [DW-1:0]     host_wdata,
   output logic [DW-1:0]     host_rdata,
   output logic              host_rvalid,
   output logic [HOFF_W-2:0] ram_addr,
   output logic              ram_re,
   output logic              ram_we,
   output logic [DW-1:0]     ram_wdata,
   input  logic [DW-1:0]     ram_rdata,
   output logic              io_req,
   output logic              io_we,
   output logic              io_byte,
   output logic [HOFF_W-1:0] io_addr,
   output logic [DW-1:0]     io_wdata,
   input  logic [DW-1:0]     io_rdata,
   input  logic [DW-1:0]     cop_set,
   input  logic [DW-1:0]     cop_clr,
   input  logic              cop_xfer_we,
   input  logic [DW-1:0]     cop_xfer_wdata,
   output logic [DW-1:0]     cop_xfer,
   output logic [DW-1:0]     cop_status,
   output logic              rel_mbox,
   output logic              rel_wake_a,
   output logic              rel_wake_b
);
   localparam int RAM_AW  = HOFF_W - 1;
   localparam int BLK_LSB = 4;
   localparam int HALF_B  = DW / 2;
   localparam logic [HOFF_W-BLK_LSB-1:0] MBOX_TAG = MBOX_BASE[HOFF_W-1:BLK_LSB];

   generate
      if (DW != 16) begin : g_chk_dw
         $error("cop_mailbox_bridge: DW must be 16");
      end
      if (HOFF_W < TILE_IW + 2) begin : g_chk_off
         $error("cop_mailbox_bridge: HOFF_W too small for tile windows");
      end
   endgenerate

   region_e rgn;
   logic    acc_rd, acc_wr, lower_half, wdata_nz;
   logic [TILE_IW-1:0] tile_w;
   logic [TILE_IW-1:0] tidx [2];

   always_comb begin
      if (host_sel_ram)                 rgn = RG_RAM;
      else if (host_sel_tile_a)         rgn = RG_TILE_A;
      else if (host_sel_tile_b)         rgn = RG_TILE_B;
      else if (host_sel_regs)
         rgn = (host_off[HOFF_W-1:BLK_LSB] == MBOX_TAG) ? RG_MBOX : RG_IO;
      else                              rgn = RG_NONE;
   end

   assign acc_rd     = host_req && !host_we;
   assign acc_wr     = host_req && host_we && !host_byte;
   assign tile_w     = host_off[TILE_IW:1];
   assign lower_half = !host_off[HOFF_W-1];
   assign wdata_nz   = |host_wdata;

   for (genvar v = 0; v < 2; v++) begin : g_tile
      cmb_tile_perm #(.VARIANT(v)) u_perm (
         .word_idx (tile_w),
         .ram_idx  (tidx[v])
      );
   end

   always_comb begin
      case (rgn)
         RG_TILE_A: ram_addr = RAM_AW'(tidx[0]);
         RG_TILE_B: ram_addr = RAM_AW'(tidx[1]);
         default:   ram_addr = host_off[HOFF_W-1:1];
      endcase
   end

   assign ram_re    = acc_rd && (rgn == RG_RAM || rgn == RG_TILE_A || rgn == RG_TILE_B);
   assign ram_we    = acc_wr && (rgn == RG_RAM);
   assign ram_wdata = host_wdata;

   assign io_req   = host_req && (rgn == RG_IO);
   assign io_we    = host_we;
   assign io_byte  = host_byte;
   assign io_addr  = host_off;
   assign io_wdata = host_wdata;

   logic [DW-1:0] mbox_rd;

   cmb_mbox_regs #(.DW(DW)) u_regs (
      .clk            (clk),
      .rst_n          (rst_n),
      .h_rd           (acc_rd && rgn == RG_MBOX),
      .h_wr           (acc_wr && rgn == RG_MBOX),
      .h_woff         (host_off[BLK_LSB-1:1]),
      .h_wdata        (host_wdata),
      .cop_set        (cop_set),
      .cop_clr        (cop_clr),
      .cop_xfer_we    (cop_xfer_we),
      .cop_xfer_wdata (cop_xfer_wdata),
      .rd_data        (mbox_rd),
      .xfer           (cop_xfer),
      .status         (cop_status),
      .rel_mbox       (rel_mbox)
   );

   region_e r_rgn;
   logic    r_byte, r_low;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_rgn       <= RG_NONE;
         r_byte      <= 1'b0;
         r_low       <= 1'b0;
         host_rvalid <= 1'b0;
         rel_wake_a  <= 1'b0;
         rel_wake_b  <= 1'b0;
      end else begin
         host_rvalid <= acc_rd;
         if (acc_rd) begin
            r_rgn  <= rgn;
            r_byte <= host_byte;
            r_low  <= host_off[0];
         end
         rel_wake_a <= ram_we && lower_half && wdata_nz && (host_off == HOFF_W'(WAKE_A_OFF));
         rel_wake_b <= ram_we && lower_half && wdata_nz && (host_off == HOFF_W'(WAKE_B_OFF));
      end
   end

   logic [DW-1:0] word_rd;

   always_comb begin
      case (r_rgn)
         RG_RAM, RG_TILE_A, RG_TILE_B: word_rd = ram_rdata;
         RG_MBOX:                      word_rd = mbox_rd;
         RG_IO:                        word_rd = io_rdata;
         default:                      word_rd = '0;
      endcase
      if (r_byte && r_rgn != RG_IO)
         host_rdata = {{HALF_B{1'b0}}, (r_low ? word_rd[HALF_B-1:0] : word_rd[DW-1:HALF_B])};
      else
         host_rdata = word_rd;
   end

   AST_TILE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && host_we && !host_sel_ram && (host_sel_tile_a || host_sel_tile_b)) |-> !ram_we); // R9
   AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_we) |=> host_rvalid); // R10
   AST_RVALID_ONLY_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |-> $past(host_req && !host_we)); // R10
   AST_WAKE_A_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rel_wake_a |-> ($past(host_wdata) != '0)); // R6
   AST_WAKE_B_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rel_wake_b |-> ($past(host_wdata) != '0)); // R6
   AST_WAKE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rel_wake_a, rel_wake_b})); // R6
endmodule

// File: tb/cop_mailbox_bridge_test.sv
module cop_mailbox_bridge_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 0, host_we = 0, host_byte = 0;
   logic        host_sel_ram = 0, host_sel_tile_a = 0, host_sel_tile_b = 0, host_sel_regs = 0;
   logic [16:0] host_off = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        host_rvalid;
   logic [15:0] ram_addr;
   logic        ram_re, ram_we;
   logic [15:0] ram_wdata;
   logic [15:0] ram_rdata = '0;
   logic        io_req, io_we, io_byte;
   logic [16:0] io_addr;
   logic [15:0] io_wdata;
   logic [15:0] io_rdata = '0;
   logic [15:0] cop_set = '0, cop_clr = '0, cop_xfer_wdata = '0;
   logic        cop_xfer_we = 0;
   logic [15:0] cop_xfer, cop_status;
   logic        rel_mbox, rel_wake_a, rel_wake_b;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic [15:0] d;
      string       tag;
   } exp_t;
   exp_t sb[$];

   logic [15:0] ram_model [int unsigned];

   always #2 clk = ~clk;

   cop_mailbox_bridge uut (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_byte(host_byte),
      .host_sel_ram(host_sel_ram), .host_sel_tile_a(host_sel_tile_a),
      .host_sel_tile_b(host_sel_tile_b), .host_sel_regs(host_sel_regs),
      .host_off(host_off), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_rvalid(host_rvalid),
      .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .io_req(io_req), .io_we(io_we), .io_byte(io_byte), .io_addr(io_addr),
      .io_wdata(io_wdata), .io_rdata(io_rdata),
      .cop_set(cop_set), .cop_clr(cop_clr), .cop_xfer_we(cop_xfer_we),
      .cop_xfer_wdata(cop_xfer_wdata), .cop_xfer(cop_xfer), .cop_status(cop_status),
      .rel_mbox(rel_mbox), .rel_wake_a(rel_wake_a), .rel_wake_b(rel_wake_b)
   );

   // synchronous RAM and I/O models
   always @(posedge clk) begin
      if (ram_we) ram_model[ram_addr] = ram_wdata;
      if (ram_re) ram_rdata <= ram_model.exists(ram_addr) ? ram_model[ram_addr] : 16'h0;
      if (io_req && !io_we) io_rdata <= io_addr[15:0] ^ 16'h3c3c;
   end

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard whenever read data is valid (R10)
   always @(negedge clk) begin
      if (rst_n && host_rvalid) begin
         if (sb.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R10: actual unexpected rvalid expected none");
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, host_rdata, e.d);
         end
      end
   end

   task automatic drive(int sel, logic we, logic bt, logic [16:0] off, logic [15:0] d);
      host_sel_ram    = (sel == 0);
      host_sel_tile_a = (sel == 1);
      host_sel_tile_b = (sel == 2);
      host_sel_regs   = (sel == 3);
      host_req = 1'b1; host_we = we; host_byte = bt; host_off = off; host_wdata = d;
   endtask

   task automatic idle();
      host_req = 1'b0; host_we = 1'b0; host_byte = 1'b0;
      host_sel_ram = 0; host_sel_tile_a = 0; host_sel_tile_b = 0; host_sel_regs = 0;
   endtask

   task automatic hread(int sel, logic bt, logic [16:0] off, logic [15:0] exp, string tag);
      exp_t e;
      e.d = exp; e.tag = tag;
      sb.push_back(e);
      drive(sel, 1'b0, bt, off, 16'h0);
      @(negedge clk);
      idle();
   endtask

   task automatic hwrite(int sel, logic [16:0] off, logic [15:0] d);
      drive(sel, 1'b1, 1'b0, off, d);
      @(negedge clk);
      idle();
   endtask

   function automatic int perm_a(int w);
      return (w & 'h7001) | ((w & 'h3e) << 6) | ((w & 'hfc0) >> 5);
   endfunction
   function automatic int perm_b(int w);
      return (w & 'h7801) | ((w & 'h1e) << 6) | ((w & 'h7e0) >> 4);
   endfunction

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int tw [4];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("reset R3 xfer", cop_xfer, 16'h0);
      check("reset R2 status", cop_status, 16'h0);
      check("reset R10 rvalid", {15'h0, host_rvalid}, 16'h0);

      // R3: host transfer write
      hwrite(3, 17'h05000, 16'hbeef);
      check("R3 xfer loaded", cop_xfer, 16'hbeef);
      check("R3 posted bit", cop_status, 16'h0002);
      check("R3 release pulse", {15'h0, rel_mbox}, 16'h1);
      @(negedge clk);
      check("R3 release one cycle", {15'h0, rel_mbox}, 16'h0);

      // R11: host and coprocessor transfer loads in one cycle
      cop_xfer_we = 1'b1; cop_xfer_wdata = 16'h1111;
      hwrite(3, 17'h05002, 16'hc0de);
      cop_xfer_we = 1'b0;
      check("R11 host wins xfer", cop_xfer, 16'hc0de);
      cop_xfer_we = 1'b1; cop_xfer_wdata = 16'h2222;
      @(negedge clk);
      cop_xfer_we = 1'b0;
      check("R11 cop xfer load", cop_xfer, 16'h2222);
      hwrite(3, 17'h05000, 16'hc0de);

      // R1
      hread(3, 1'b0, 17'h05000, 16'hc0de, "R1 offset 0");
      hread(3, 1'b0, 17'h05002, 16'hc0de, "R1 offset 2");

      // R11 set, R2 read-to-clear
      cop_set = 16'h0001;
      @(negedge clk);
      cop_set = 16'h0;
      check("R11 cop set", cop_status, 16'h0003);
      hread(3, 1'b0, 17'h05004, 16'h0003, "R2 status value");
      check("R2 bit0 cleared", cop_status, 16'h0002);

      // R11: set wins over read-to-clear in the same cycle
      cop_set = 16'h0001;
      @(negedge clk);
      hread(3, 1'b0, 17'h05004, 16'h0003, "R11 read during set");
      cop_set = 16'h0;
      check("R11 set beats clear", cop_status, 16'h0003);

      // R7 byte reads
      hread(3, 1'b1, 17'h05005, 16'h0003, "R7 status low byte");
      check("R7 byte read clears", cop_status, 16'h0002);
      hread(3, 1'b1, 17'h05000, 16'h00c0, "R7 even upper byte");
      hread(3, 1'b1, 17'h05001, 16'h00de, "R7 odd lower byte");

      // R11 clear
      cop_clr = 16'h0002;
      @(negedge clk);
      cop_clr = 16'h0;
      check("R11 cop clear", cop_status, 16'h0000);

      // R12
      hwrite(3, 17'h05004, 16'hffff);
      check("R12 write off4 status", cop_status, 16'h0000);
      hwrite(3, 17'h05006, 16'h1234);
      check("R12 write off6 xfer", cop_xfer, 16'hc0de);
      check("R12 write off6 status", cop_status, 16'h0000);
      hread(3, 1'b0, 17'h05008, 16'h0000, "R12 read off8");
      hread(3, 1'b0, 17'h0500e, 16'h0000, "R12 read off14");

      // R8 I/O forwarding
      drive(3, 1'b0, 1'b0, 17'h05010, 16'h0);
      #1;
      check("R8 io_req on read", {15'h0, io_req}, 16'h1);
      check("R8 io_addr", io_addr[15:0], 16'h5010);
      sb.push_back('{d: 16'h5010 ^ 16'h3c3c, tag: "R8 io read data"});
      @(negedge clk);
      idle();
      drive(3, 1'b1, 1'b0, 17'h00020, 16'h4321);
      #1;
      check("R8 io write req", {14'h0, io_req, io_we}, 16'h3);
      check("R8 io wdata", io_wdata, 16'h4321);
      @(negedge clk);
      idle();

      // R4 / R5: tile windows
      tw[0] = 'h1234; tw[1] = 'h7fff; tw[2] = 'h0041; tw[3] = 'h2fc3;
      foreach (tw[i]) begin
         int p;
         p = perm_a(tw[i]);
         hwrite(0, 17'(p * 2), 16'(p) ^ 16'ha5c3);
         p = perm_b(tw[i]);
         hwrite(0, 17'(p * 2), 16'(p) ^ 16'ha5c3);
      end
      foreach (tw[i]) begin
         hread(1, 1'b0, 17'(tw[i] * 2), 16'(perm_a(tw[i])) ^ 16'ha5c3, "R4 tile A");
         hread(2, 1'b0, 17'(tw[i] * 2), 16'(perm_b(tw[i])) ^ 16'ha5c3, "R5 tile B");
      end

      // R9: tile writes ignored
      drive(1, 1'b1, 1'b0, 17'(tw[0] * 2), 16'hdead);
      #1;
      check("R9 tile A no ram_we", {15'h0, ram_we}, 16'h0);
      @(negedge clk);
      drive(2, 1'b1, 1'b0, 17'(tw[0] * 2), 16'hdead);
      #1;
      check("R9 tile B no ram_we", {15'h0, ram_we}, 16'h0);
      @(negedge clk);
      idle();
      hread(1, 1'b0, 17'(tw[0] * 2), 16'(perm_a(tw[0])) ^ 16'ha5c3, "R9 tile data intact");

      // R6 wake strobes
      hwrite(0, 17'h0fe06, 16'h1234);
      check("R6 wake A pulse", {14'h0, rel_wake_a, rel_wake_b}, 16'h2);
      hwrite(0, 17'h0fe08, 16'h0077);
      check("R6 wake B pulse", {14'h0, rel_wake_a, rel_wake_b}, 16'h1);
      hwrite(0, 17'h0fe08, 16'h0000);
      check("R6 zero no wake", {14'h0, rel_wake_a, rel_wake_b}, 16'h0);
      hread(0, 1'b0, 17'h0fe08, 16'h0000, "R6 zero stored");
      hwrite(0, 17'h1fe06, 16'h5555);
      check("R6 upper half no wake", {14'h0, rel_wake_a, rel_wake_b}, 16'h0);
      hread(0, 1'b0, 17'h1fe06, 16'h5555, "R6 upper half stored");
      hread(0, 1'b1, 17'h0fe07, 16'h0034, "R7 RAM odd byte");

      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         n_chk++; n_bad++;
         $display("FAIL R10: actual %0d pending expected 0", sb.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule